// File: doc/BRIEF.md
# Vector Widening Shift-Left Lane Unit

This block performs a widening logical left shift over a packed group of vector elements in one clocked step. Each source element of SEW bits is zero-extended to 2×SEW bits and shifted left. The shift amount is cut down to the range 0 to 2×SEW−1.

The shift amount comes from one of three places, chosen by the instruction word: a second source vector (one amount per element), a scalar register value applied to every element, or a 5-bit unsigned immediate. A per-element mask, together with the instruction's vm bit, decides which destination elements take the new result. The others keep the old destination contents supplied by the caller.

A caller raises `i_issue` for one cycle together with the instruction word, the element-width select and the operands. On the next cycle the unit shows the packed destination with `o_done` high. It also raises `o_vstart_clr` to tell the surrounding pipeline that the vector start index returns to zero. The result stays on `o_dest` until the next issue.

A two-state controller sequences the unit:
- `ST_IDLE` is the waiting state.
- `ST_RESP` holds for the one cycle after an issue.
- Transitions: IDLE→RESP on issue, RESP→RESP on a back-to-back issue, and RESP→IDLE when no issue arrives.

Top module: `wsl_unit`

## Requirements
- R1: An instruction is legal only when all of the following hold:
  - bits [31:26] are 110101;
  - bits [6:0] are 1010111;
  - bits [14:12] are 000 (vector-vector), 100 (vector-scalar) or 011 (immediate).
  Bit 25 is vm, and bits [19:15] carry the immediate. Any other word is illegal: `o_illegal` is 1, `o_dest` equals the old destination, and `o_vstart_clr` stays 0.
- R2: `i_sew` selects the source element width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. The value 3 is illegal and is handled as in R1.
- R3: Packing. Source element e sits at bits [e×SEW +: SEW] of `i_vs2` and `i_vs1`. Destination element e sits at bits [e×2×SEW +: 2×SEW] of `o_dest`. Destination bits above NUM_ELEM×2×SEW equal the old destination.
- R4: An active element's result is the source element, zero-extended to 2×SEW bits, shifted left with zeros filling from the right. No bits are kept beyond 2×SEW.
- R5: The shift amount used is the operand ANDed with 2×SEW−1. For example, an amount of 2×SEW shifts by 0.
- R6: In the vector-vector variant, element e's amount is element e of `i_vs1`, taken at SEW width.
- R7: In the vector-scalar variant, every element uses the low SEW bits of `i_scalar`. Higher bits of `i_scalar` have no effect.
- R8: In the immediate variant, every element uses the 5-bit immediate, zero-extended.
- R9: With vm=1 every element is active. With vm=0, element e is active only when `i_mask[e]` is 1. An inactive element keeps its old destination value.
- R10: `o_done` is 1 exactly in the cycle after an issue. `o_dest` and `o_illegal` hold until the next issue. `o_vstart_clr` is 1 in that cycle for a legal operation.
- R11: After reset, `o_done`, `o_illegal` and `o_vstart_clr` are 0, and `o_dest` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_issue | input | 1 | Starts one operation |
| i_instr | input | 32 | Instruction word |
| i_sew | input | 2 | Source element width select |
| i_vs2 | input | NUM_ELEM×32 | Packed source elements to shift |
| i_vs1 | input | NUM_ELEM×32 | Packed per-element shift amounts |
| i_scalar | input | 32 | Scalar shift amount |
| i_mask | input | NUM_ELEM | Per-element mask |
| i_old_dest | input | NUM_ELEM×64 | Previous destination contents |
| o_done | output | 1 | Result valid (one cycle after issue) |
| o_illegal | output | 1 | Issued instruction or width was illegal |
| o_vstart_clr | output | 1 | Start index returns to zero |
| o_dest | output | NUM_ELEM×64 | Packed widened destination |

## Verification
Every result of this unit is registered. The destination, the illegal flag and the start-index pulse therefore all become due one clock edge after the issue edge. The bench drives each operation on a falling edge and lets one rising edge capture it. It then compares all outputs on the following falling edge, away from any active edge. It then idles for one more cycle and checks that `o_done` has dropped while `o_dest` and `o_illegal` kept their values. This covers the one-cycle pulse and the hold behaviour.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
    localparam int MAX_SEW   = 32;
    localparam int SEW_KINDS = 3;

    localparam logic [5:0] OP_FUNCT6 = 6'b110101;
    localparam logic [6:0] OP_MAJOR  = 7'b1010111;
    localparam logic [2:0] F3_VV     = 3'b000;
    localparam logic [2:0] F3_VX     = 3'b100;
    localparam logic [2:0] F3_VI     = 3'b011;

    typedef enum logic [1:0] {
        VAR_VV  = 2'd0,
        VAR_VX  = 2'd1,
        VAR_VI  = 2'd2,
        VAR_BAD = 2'd3
    } wsl_var_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } wsl_state_e;
endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
    import wsl_pkg::*;
(
    input  logic [31:0] i_instr,
    input  logic [1:0]  i_sew,
    output wsl_var_e    o_var,
    output logic        o_vm,
    output logic [4:0]  o_imm,
    output logic        o_legal
);
    logic match_op;
    logic unused_fields;

    assign unused_fields = ^{i_instr[24:20], i_instr[11:7]};
    assign match_op = (i_instr[31:26] == OP_FUNCT6) && (i_instr[6:0] == OP_MAJOR);
    assign o_vm     = i_instr[25];
    assign o_imm    = i_instr[19:15];

    always_comb begin
        o_var = VAR_BAD;
        if (match_op) begin
            unique case (i_instr[14:12])
                F3_VV:   o_var = VAR_VV;
                F3_VX:   o_var = VAR_VX;
                F3_VI:   o_var = VAR_VI;
                default: o_var = VAR_BAD;
            endcase
        end
    end

    assign o_legal = (o_var != VAR_BAD) && (i_sew != 2'd3);

    // R2: width code 3 never yields a legal operation
    always_comb begin
        if (i_sew == 2'd3) assert_sew3_illegal_R2: assert (!o_legal);
    end
endmodule

// File: rtl/wsl_lanes.sv
module wsl_lanes
    import wsl_pkg::*;
#(
    parameter int NUM_ELEM = 4
) (
    input  logic [1:0]                     i_sew,
    input  wsl_var_e                       i_var,
    input  logic                           i_vm,
    input  logic [4:0]                     i_imm,
    input  logic [NUM_ELEM*MAX_SEW-1:0]    i_vs2,
    input  logic [NUM_ELEM*MAX_SEW-1:0]    i_vs1,
    input  logic [MAX_SEW-1:0]             i_scalar,
    input  logic [NUM_ELEM-1:0]            i_mask,
    input  logic [NUM_ELEM*2*MAX_SEW-1:0]  i_old,
    output logic [NUM_ELEM*2*MAX_SEW-1:0]  o_res
);
    localparam int DST_W = NUM_ELEM * 2 * MAX_SEW;

    for (genvar k = 0; k < SEW_KINDS; k++) begin : g_sew
        localparam int SW = 8 << k;
        localparam int DW = 2 * SW;
        localparam int AW = $clog2(DW);
        logic [DST_W-1:0] cand;

        for (genvar e = 0; e < NUM_ELEM; e++) begin : g_el
            logic [SW-1:0] src;
            logic [SW-1:0] opnd;
            logic [AW-1:0] amt;
            logic [DW-1:0] wide;

            always_comb begin
                src = i_vs2[e*SW +: SW];
                unique case (i_var)
                    VAR_VV:  opnd = i_vs1[e*SW +: SW];
                    VAR_VX:  opnd = i_scalar[SW-1:0];
                    default: opnd = SW'(i_imm);
                endcase
                // keeping the low AW bits equals masking with DW-1
                amt  = opnd[AW-1:0];
                wide = DW'(src) << amt;
            end

            assign cand[e*DW +: DW] = (i_vm || i_mask[e]) ? wide : i_old[e*DW +: DW];

            // R4: the bits of a widened result below the shift are zero
            always_comb begin
                if ((i_vm || i_mask[e]) && amt != '0)
                    assert_zero_fill_R4: assert (cand[e*DW] == 1'b0);
            end
        end

        if (NUM_ELEM * DW < DST_W) begin : g_upper
            assign cand[DST_W-1:NUM_ELEM*DW] = i_old[DST_W-1:NUM_ELEM*DW];
        end
    end

    always_comb begin
        unique case (i_sew)
            2'd0:    o_res = g_sew[0].cand;
            2'd1:    o_res = g_sew[1].cand;
            2'd2:    o_res = g_sew[2].cand;
            default: o_res = i_old;
        endcase
    end
endmodule

// File: rtl/wsl_unit.sv
module wsl_unit
    import wsl_pkg::*;
#(
    parameter int NUM_ELEM = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           i_issue,
    input  logic [31:0]                    i_instr,
    input  logic [1:0]                     i_sew,
    input  logic [NUM_ELEM*MAX_SEW-1:0]    i_vs2,
    input  logic [NUM_ELEM*MAX_SEW-1:0]    i_vs1,
    input  logic [MAX_SEW-1:0]             i_scalar,
    input  logic [NUM_ELEM-1:0]            i_mask,
    input  logic [NUM_ELEM*2*MAX_SEW-1:0]  i_old_dest,
    output logic                           o_done,
    output logic                           o_illegal,
    output logic                           o_vstart_clr,
    output logic [NUM_ELEM*2*MAX_SEW-1:0]  o_dest
);
    localparam int DST_W = NUM_ELEM * 2 * MAX_SEW;

    wsl_state_e        state_q, state_d;
    wsl_var_e          dec_var;
    logic              dec_vm;
    logic [4:0]        dec_imm;
    logic              dec_legal;
    logic [DST_W-1:0]  lane_res;

    wsl_decode u_decode (
        .i_instr (i_instr),
        .i_sew   (i_sew),
        .o_var   (dec_var),
        .o_vm    (dec_vm),
        .o_imm   (dec_imm),
        .o_legal (dec_legal)
    );

    wsl_lanes #(.NUM_ELEM(NUM_ELEM)) u_lanes (
        .i_sew    (i_sew),
        .i_var    (dec_var),
        .i_vm     (dec_vm),
        .i_imm    (dec_imm),
        .i_vs2    (i_vs2),
        .i_vs1    (i_vs1),
        .i_scalar (i_scalar),
        .i_mask   (i_mask),
        .i_old    (i_old_dest),
        .o_res    (lane_res)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = i_issue ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = i_issue ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_dest       <= '0;
            o_illegal    <= 1'b0;
            o_vstart_clr <= 1'b0;
        end else if (i_issue) begin
            o_dest       <= dec_legal ? lane_res : i_old_dest;
            o_illegal    <= !dec_legal;
            o_vstart_clr <= dec_legal;
        end else begin
            o_vstart_clr <= 1'b0;
        end
    end

    assign o_done = (state_q == ST_RESP);

    assert_done_after_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        i_issue |=> o_done);
    assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !i_issue |=> !o_done);
    assert_vstart_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (i_issue && dec_legal) |=> o_vstart_clr);
    assert_illegal_keeps_old_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (i_issue && !dec_legal) |=> (o_illegal && !o_vstart_clr && o_dest == $past(i_old_dest)));
    assert_inactive_elem0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (i_issue && dec_legal && !dec_vm && !i_mask[0]) |=> (o_dest[15:0] == $past(i_old_dest[15:0])));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !i_issue |=> $stable(o_dest));
endmodule

// File: tb/test_wsl_unit.sv
module test_wsl_unit;
    localparam int NE    = 4;
    localparam int SRC_W = NE * 32;
    localparam int DST_W = NE * 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue = 1'b0;
    logic [31:0]       instr = '0;
    logic [1:0]        sew = '0;
    logic [SRC_W-1:0]  vs2 = '0;
    logic [SRC_W-1:0]  vs1 = '0;
    logic [31:0]       scalar = '0;
    logic [NE-1:0]     mask = '0;
    logic [DST_W-1:0]  old_dest = '0;
    logic              done, illegal, vclr;
    logic [DST_W-1:0]  dest;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wsl_unit #(.NUM_ELEM(NE)) i_wsl_unit (
        .clk(clk), .rst_n(rst_n), .i_issue(issue), .i_instr(instr), .i_sew(sew),
        .i_vs2(vs2), .i_vs1(vs1), .i_scalar(scalar), .i_mask(mask), .i_old_dest(old_dest),
        .o_done(done), .o_illegal(illegal), .o_vstart_clr(vclr), .o_dest(dest)
    );

    function automatic logic [31:0] mk(input logic [2:0] f3, input logic vm, input logic [4:0] imm);
        return {6'b110101, vm, 5'd2, imm, f3, 5'd4, 7'b1010111};
    endfunction

    function automatic bit ref_legal(input logic [31:0] in, input logic [1:0] s);
        logic [2:0] f3 = in[14:12];
        return (in[31:26] == 6'b110101) && (in[6:0] == 7'b1010111) && (s != 2'd3)
               && (f3 == 3'b000 || f3 == 3'b100 || f3 == 3'b011);
    endfunction

    function automatic logic [DST_W-1:0] ref_dest(input logic [31:0] in, input logic [1:0] s,
            input logic [SRC_W-1:0] a, input logic [SRC_W-1:0] b, input logic [31:0] sc,
            input logic [NE-1:0] m, input logic [DST_W-1:0] old);
        logic [DST_W-1:0] r = old;
        int w, amt;
        logic [DST_W-1:0] m2, src, opnd, val;
        if (!ref_legal(in, s)) return old;
        w  = 8 << s;
        m2 = (DST_W'(1) << (2*w)) - 1;
        for (int e = 0; e < NE; e++) begin
            if (in[25] || m[e]) begin
                src = (DST_W'(a) >> (e*w)) & ((DST_W'(1) << w) - 1);
                if (in[14:12] == 3'b000)      opnd = (DST_W'(b) >> (e*w)) & ((DST_W'(1) << w) - 1);
                else if (in[14:12] == 3'b100) opnd = DST_W'(sc) & ((DST_W'(1) << w) - 1);
                else                          opnd = DST_W'(in[19:15]);
                amt = int'(opnd & DST_W'(2*w - 1));
                val = (src << amt) & m2;
                r = (r & ~(m2 << (e*2*w))) | (val << (e*2*w));
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DST_W-1:0] act, input logic [DST_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] in, input logic [1:0] s, input logic [SRC_W-1:0] a,
            input logic [SRC_W-1:0] b, input logic [31:0] sc, input logic [NE-1:0] m,
            input logic [DST_W-1:0] old, input string req);
        logic [DST_W-1:0] exp_d;
        bit lg;
        exp_d = ref_dest(in, s, a, b, sc, m, old);
        lg    = ref_legal(in, s);
        instr = in; sew = s; vs2 = a; vs1 = b; scalar = sc; mask = m; old_dest = old;
        issue = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0;
        vs2 = ~vs2; old_dest = ~old_dest;
        chk(dest == exp_d, req, dest, exp_d);
        chk(done && illegal == !lg && vclr == lg, {req, " R10 R1 flags"},
            DST_W'({done, illegal, vclr}), DST_W'({1'b1, !lg, lg}));
        @(posedge clk);
        @(negedge clk);
        chk(!done && !vclr && dest == exp_d && illegal == !lg, {req, " R10 hold"}, dest, exp_d);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [SRC_W-1:0] a, b;
        logic [DST_W-1:0] o;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!done && !illegal && !vclr && dest == '0, "R11 reset", dest, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < 3; s++) begin
            int w = 8 << s;
            a = {SRC_W/32{32'hC3A5_9E81}};
            o = {DST_W/32{32'h5A5A_5A5A}};
            // R5 R6: amounts 0, 2w-1, 2w (wraps to 0), 2w+3
            b = '0;
            for (int e = 0; e < NE; e++) begin
                logic [31:0] v;
                v = (e == 0) ? 0 : (e == 1) ? 2*w-1 : (e == 2) ? 2*w : 2*w+3;
                b[e*w +: 8] = v[7:0];
            end
            run_op(mk(3'b000, 1'b1, 5'd0), 2'(s), a, b, 0, '0, o, "R5 R6 R3 vv truncation");
            // R4: all-ones element shifted by 2w-1 leaves only the top bit
            run_op(mk(3'b100, 1'b1, 5'd0), 2'(s), '1, '0, 2*w-1, '0, o, "R4 R7 vx max shift");
            run_op(mk(3'b100, 1'b1, 5'd0), 2'(s), a, '0, 2*w, '0, o, "R5 R7 vx wraps to zero");
            // R7: scalar bits above SEW are ignored
            run_op(mk(3'b100, 1'b1, 5'd0), 2'(s), a, '0, 32'hFFFF_FF00 & ~((32'd1 << w) - 1) | 32'd3,
                   '0, o, "R7 vx high bits ignored");
            run_op(mk(3'b011, 1'b1, 5'd31), 2'(s), a, '0, 0, '0, o, "R8 vi imm 31");
            run_op(mk(3'b011, 1'b0, 5'd4), 2'(s), a, '0, 0, 4'b0101, o, "R9 vi masked");
            run_op(mk(3'b000, 1'b0, 5'd0), 2'(s), a, b, 0, 4'b0000, o, "R9 all inactive");
        end
        // R2: width code 3 is illegal
        run_op(mk(3'b000, 1'b1, 5'd0), 2'd3, '1, '1, 0, '1, {DST_W/32{32'h1234_5678}}, "R2 sew3 illegal");
        // R1: bad funct3, funct6, major opcode
        run_op(mk(3'b001, 1'b1, 5'd1), 2'd0, '1, '1, 1, '1, {DST_W/32{32'hABCD_0001}}, "R1 bad funct3");
        run_op(mk(3'b000, 1'b1, 5'd1) ^ 32'h0400_0000, 2'd1, '1, '1, 1, '1, '0, "R1 bad funct6");
        run_op(mk(3'b011, 1'b1, 5'd1) ^ 32'h0000_0001, 2'd2, '1, '1, 1, '1, '1, "R1 bad opcode");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] f3;
            logic [31:0] in;
            int pick = $urandom_range(0, 9);
            f3 = (pick < 3) ? 3'b000 : (pick < 6) ? 3'b100 : (pick < 9) ? 3'b011 : 3'($urandom);
            in = mk(f3, 1'($urandom), 5'($urandom));
            for (int q = 0; q < SRC_W/32; q++) begin
                a[q*32 +: 32] = $urandom;
                b[q*32 +: 32] = $urandom;
            end
            for (int q = 0; q < DST_W/32; q++) o[q*32 +: 32] = $urandom;
            run_op(in, 2'($urandom_range(0, 2)), a, b, $urandom, 4'($urandom), o, "R3 R9 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule